// File: doc/BRIEF.md
# Dual-Port Interrupt-on-Change GPIO

This block is a 16-pin general-purpose I/O controller split into two 8-bit ports, A and B. Each port has its own bank of control registers. Per pin, these set the direction, the polarity of the reported input, the pull-up enable, the interrupt enable, a reference level and the compare mode. Every input pin passes through a two-flop synchroniser and a stable-count qualifier before any logic sees it, so short pulses are discarded.

An enabled input pin raises its interrupt in one of two ways, chosen per pin. In change mode it fires whenever its filtered level changes. In reference mode it fires whenever the level differs from a stored reference bit. When a port's flag set goes from empty to non-empty, the port's reported value is latched into a capture register. Reading the port value or the capture register clears that port's flags.

The two interrupt lines can be routed separately or mirrored, and can be driven active-low, driven active-high, or run as open-drain. A host reaches all registers over a simple parallel bus with a one-cycle read latency.

Top module: `gpio_ioc`

Register address `bus_addr[4]` selects the port (0 = A, 1 = B). `bus_addr[3:0]` selects the field:

| Field | Name | Access | Reset | Meaning |
|---|---|---|---|---|
| 0 | DIR | rw | 0xFF | 1 = input, 0 = output |
| 1 | POL | rw | 0x00 | 1 = invert the reported bit |
| 2 | IEN | rw | 0x00 | 1 = interrupt enabled |
| 3 | DEFV | rw | 0x00 | reference level |
| 4 | CMPS | rw | 0x00 | 1 = reference mode, 0 = change mode |
| 5 | PUEN | rw | 0x00 | pull-up enable |
| 6 | PORT | r / w | - | read: reported value (clears flags); write: output latch |
| 7 | OLAT | rw | 0x00 | output latch |
| 8 | FLAG | r | 0x00 | pending interrupt bits |
| 9 | CAPT | r | 0x00 | captured value (clears flags) |
| 10 | CFG | rw | 0x00 | shared: bit0 mirror, bit1 open-drain, bit2 active-high |

## Requirements
- R1: During and after reset every pin is an input (pin_oe all 0), DIR reads 0xFF and CFG reads 0x00. While rst_n is low, pin_oe, irq_a_oe and irq_b_oe are 0. After reset the interrupt lines are inactive: output high with oe high.
- R2: A pin whose DIR bit is 0 has its pin_oe bit set, and pin_out carries the output latch written through field 6 or field 7.
- R3: A read of field 6 returns the filtered pin levels XOR the POL register, one cycle after bus_rd.
- R4: A pin level reaches the port logic only after it has held for FILT_CYCLES consecutive synchronised samples. A pulse lasting FILT_CYCLES-1 cycles changes neither the PORT value nor any flag.
- R5: In change mode (CMPS bit 0), each change of the filtered level of an enabled input pin sets its FLAG bit.
- R6: In reference mode (CMPS bit 1), an enabled input pin sets its FLAG bit while its filtered, non-inverted level differs from its DEFV bit. The flag sets again after a clear while the mismatch persists.
- R7: A pin with IEN bit 0, or with DIR bit 0, never sets a flag.
- R8: When a port's flags go from all-zero to non-zero, CAPT loads the reported value of that port at that moment. CAPT then holds while any flag of the port remains set.
- R9: Reading field 6 or field 9 of a port clears all FLAG bits of that port. Reading field 8 leaves them unchanged.
- R10: With CFG bit0 at 0, port A flags drive only irq_a and port B flags drive only irq_b. With CFG bit0 at 1, both lines show the OR of both ports.
- R11: With CFG bit1 at 0 a line is always driven (oe = 1): low when active if bit2 is 0, high when active if bit2 is 1. With bit1 at 1 the output value is 0 and oe is 1 only while active.
- R12: pin_pu equals the PUEN registers ({port B, port A}).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset; also forces high impedance |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe |
| bus_addr | input | 5 | {port select, field} |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, valid the cycle after bus_rd |
| pin_in | input | 16 | pad input levels {B, A} |
| pin_out | output | 16 | output latch to the pads |
| pin_oe | output | 16 | pad output enable |
| pin_pu | output | 16 | pull-up enable |
| irq_a_o | output | 1 | interrupt line A value |
| irq_a_oe | output | 1 | interrupt line A enable |
| irq_b_o | output | 1 | interrupt line B value |
| irq_b_oe | output | 1 | interrupt line B enable |

## Verification
Interrupt detection is exercised with three kinds of input. A pulse one cycle shorter than the qualifier window separates a working filter from a pass-through. A pulse longer than the window, in change mode, shows that both edges are flagged and that the capture holds the first edge. A held mismatch in reference mode tells a level compare from an edge detect, because the flag returns after being cleared. Toggling a disabled pin and a pin configured as output separates the enable and direction masks. Sweeping the CFG settings with a single port flagged shows which routing and drive mode is in effect.

// File: rtl/gpio_ioc_pkg.sv
// Package: field codes and the interrupt configuration type shared by
// the GPIO blocks. Assumes a 4-bit field index within each port bank.
package gpio_ioc_pkg;
    localparam int FIELD_W = 4;

    localparam logic [FIELD_W-1:0] F_DIR  = 4'd0;
    localparam logic [FIELD_W-1:0] F_POL  = 4'd1;
    localparam logic [FIELD_W-1:0] F_IEN  = 4'd2;
    localparam logic [FIELD_W-1:0] F_DEFV = 4'd3;
    localparam logic [FIELD_W-1:0] F_CMPS = 4'd4;
    localparam logic [FIELD_W-1:0] F_PUEN = 4'd5;
    localparam logic [FIELD_W-1:0] F_PORT = 4'd6;
    localparam logic [FIELD_W-1:0] F_OLAT = 4'd7;
    localparam logic [FIELD_W-1:0] F_FLAG = 4'd8;
    localparam logic [FIELD_W-1:0] F_CAPT = 4'd9;
    localparam logic [FIELD_W-1:0] F_CFG  = 4'd10;

    typedef struct packed {
        logic act_high;    // bit2
        logic open_drain;  // bit1
        logic mirror;      // bit0
    } irq_cfg_t;
endpackage

// File: rtl/gpio_ioc_filter.sv
// Input qualifier: per bit, a two-flop synchroniser followed by a counter.
// The counter accepts a new level once it has held for FILT_CYCLES
// consecutive samples. Assumes FILT_CYCLES >= 1.
module gpio_ioc_filter #(
    parameter int W           = 8,
    parameter int FILT_CYCLES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] filt
);
    localparam int CNT_W = $clog2(FILT_CYCLES) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic             s1, s2, q;
        logic [CNT_W-1:0] cnt;

        // Synchronise the pad level and qualify it by run length.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1  <= 1'b0;
                s2  <= 1'b0;
                q   <= 1'b0;
                cnt <= '0;
            end else begin
                s1 <= raw[i];
                s2 <= s1;
                if (s2 == q) begin
                    cnt <= '0;
                end else if (cnt == CNT_LAST) begin
                    q   <= s2;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end

        assign filt[i] = q;
    end
endmodule

// File: rtl/gpio_ioc_bank.sv
// One port bank: the control registers, interrupt detection, flag and
// capture registers, and a combinational read value for the top-level mux.
// Assumes sel_wr/sel_rd are already qualified by the port select.
module gpio_ioc_bank
    import gpio_ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic               sel_rd,
    input  logic [FIELD_W-1:0] field,
    input  logic [W-1:0]       wdata,
    input  logic [W-1:0]       pin_filt,
    output logic [W-1:0]       rd_val,
    output logic [W-1:0]       dir,
    output logic [W-1:0]       olat,
    output logic [W-1:0]       puen,
    output logic [W-1:0]       flag,
    output logic [W-1:0]       capt
);
    logic [W-1:0] pol, ien, defv, cmps, prev;
    logic [W-1:0] reported, mismatch, hit;
    logic         clr;

    // Value presented to the host, and per-pin interrupt conditions.
    always_comb begin
        reported = pin_filt ^ pol;
        for (int i = 0; i < W; i++) begin
            mismatch[i] = cmps[i] ? (pin_filt[i] ^ defv[i])
                                  : (pin_filt[i] ^ prev[i]);
        end
        hit = ien & dir & mismatch;
        clr = sel_rd && (field == F_PORT || field == F_CAPT);
    end

    // Host-writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir  <= '1;
            pol  <= '0;
            ien  <= '0;
            defv <= '0;
            cmps <= '0;
            puen <= '0;
            olat <= '0;
        end else if (sel_wr) begin
            case (field)
                F_DIR:          dir  <= wdata;
                F_POL:          pol  <= wdata;
                F_IEN:          ien  <= wdata;
                F_DEFV:         defv <= wdata;
                F_CMPS:         cmps <= wdata;
                F_PUEN:         puen <= wdata;
                F_PORT, F_OLAT: olat <= wdata;
                default: ;
            endcase
        end
    end

    // Previous level, flag accumulation and capture on the first event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            flag <= '0;
            capt <= '0;
        end else begin
            prev <= pin_filt;
            if (clr) begin
                flag <= '0;
            end else begin
                flag <= flag | hit;
                if (flag == '0 && hit != '0) capt <= reported;
            end
        end
    end

    // Read value selection for this bank.
    always_comb begin
        case (field)
            F_DIR:   rd_val = dir;
            F_POL:   rd_val = pol;
            F_IEN:   rd_val = ien;
            F_DEFV:  rd_val = defv;
            F_CMPS:  rd_val = cmps;
            F_PUEN:  rd_val = puen;
            F_PORT:  rd_val = reported;
            F_OLAT:  rd_val = olat;
            F_FLAG:  rd_val = flag;
            F_CAPT:  rd_val = capt;
            default: rd_val = '0;
        endcase
    end
endmodule

// File: rtl/gpio_ioc_irq_out.sv
// Interrupt line driver: routing (separate or mirrored) and drive mode
// (active-low, active-high, open-drain). Forces high impedance in reset.
module gpio_ioc_irq_out
    import gpio_ioc_pkg::*;
(
    input  logic     rst_n,
    input  irq_cfg_t cfg,
    input  logic     any_a,
    input  logic     any_b,
    output logic     irq_a_o,
    output logic     irq_a_oe,
    output logic     irq_b_o,
    output logic     irq_b_oe
);
    logic act_a, act_b;

    // Route the port requests and encode each line's drive.
    always_comb begin
        act_a = cfg.mirror ? (any_a | any_b) : any_a;
        act_b = cfg.mirror ? (any_a | any_b) : any_b;
        if (cfg.open_drain) begin
            irq_a_o  = 1'b0;
            irq_b_o  = 1'b0;
            irq_a_oe = rst_n & act_a;
            irq_b_oe = rst_n & act_b;
        end else begin
            irq_a_o  = cfg.act_high ? act_a : ~act_a;
            irq_b_o  = cfg.act_high ? act_b : ~act_b;
            irq_a_oe = rst_n;
            irq_b_oe = rst_n;
        end
    end
endmodule

// File: rtl/gpio_ioc.sv
// Top: two GPIO port banks behind a parallel register bus, an input
// qualifier and interrupt line drivers. Reads are registered (one-cycle
// latency). The CFG field is shared and decoded at either port address.
module gpio_ioc
    import gpio_ioc_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int FILT_CYCLES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [FIELD_W:0]      bus_addr,
    input  logic [PORT_W-1:0]     bus_wdata,
    output logic [PORT_W-1:0]     bus_rdata,
    input  logic [2*PORT_W-1:0]   pin_in,
    output logic [2*PORT_W-1:0]   pin_out,
    output logic [2*PORT_W-1:0]   pin_oe,
    output logic [2*PORT_W-1:0]   pin_pu,
    output logic                  irq_a_o,
    output logic                  irq_a_oe,
    output logic                  irq_b_o,
    output logic                  irq_b_oe
);
    localparam int NPORT = 2;
    localparam int PIN_W = NPORT * PORT_W;
    localparam int CFG_W = $bits(irq_cfg_t);

    logic [FIELD_W-1:0] field;
    logic               psel;
    logic [PIN_W-1:0]   pin_filt;
    logic [PORT_W-1:0]  bank_rd   [NPORT];
    logic [PORT_W-1:0]  port_dir  [NPORT];
    logic [PORT_W-1:0]  port_olat [NPORT];
    logic [PORT_W-1:0]  port_puen [NPORT];
    logic [PORT_W-1:0]  port_flag [NPORT];
    logic [PORT_W-1:0]  port_capt [NPORT];
    irq_cfg_t           cfg;

    assign field = bus_addr[FIELD_W-1:0];
    assign psel  = bus_addr[FIELD_W];

    gpio_ioc_filter #(.W(PIN_W), .FILT_CYCLES(FILT_CYCLES)) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pin_in),
        .filt  (pin_filt)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_bank
        gpio_ioc_bank #(.W(PORT_W)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_wr   (bus_wr && (psel == p[0])),
            .sel_rd   (bus_rd && (psel == p[0])),
            .field    (field),
            .wdata    (bus_wdata),
            .pin_filt (pin_filt[p*PORT_W +: PORT_W]),
            .rd_val   (bank_rd[p]),
            .dir      (port_dir[p]),
            .olat     (port_olat[p]),
            .puen     (port_puen[p]),
            .flag     (port_flag[p]),
            .capt     (port_capt[p])
        );
        assign pin_out[p*PORT_W +: PORT_W] = port_olat[p];
        assign pin_oe [p*PORT_W +: PORT_W] = ~port_dir[p] & {PORT_W{rst_n}};
        assign pin_pu [p*PORT_W +: PORT_W] = port_puen[p];
    end

    // Shared interrupt line configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cfg <= '0;
        else if (bus_wr && field == F_CFG) cfg <= irq_cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)             bus_rdata <= '0;
        else if (bus_rd) begin
            if (field == F_CFG) bus_rdata <= PORT_W'(cfg);
            else                bus_rdata <= bank_rd[psel];
        end
    end

    gpio_ioc_irq_out irq_i (
        .rst_n    (rst_n),
        .cfg      (cfg),
        .any_a    (|port_flag[0]),
        .any_b    (|port_flag[1]),
        .irq_a_o  (irq_a_o),
        .irq_a_oe (irq_a_oe),
        .irq_b_o  (irq_b_o),
        .irq_b_oe (irq_b_oe)
    );
endmodule

// File: rtl/gpio_ioc_chk.sv
// Checker for gpio_ioc: reset tristate, clear-on-read, capture hold,
// mirroring and open-drain behaviour. Attached by bind below.
module gpio_ioc_chk
    import gpio_ioc_pkg::*;
#(
    parameter int W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic [FIELD_W:0] bus_addr,
    input logic [2*W-1:0]   pin_oe,
    input logic             irq_a_o,
    input logic             irq_a_oe,
    input logic             irq_b_o,
    input logic             irq_b_oe,
    input logic [W-1:0]     flag_a,
    input logic [W-1:0]     flag_b,
    input logic [W-1:0]     capt_a,
    input irq_cfg_t         cfg
);
    // Outputs are high impedance while reset is held.
    always_comb begin
        if (!rst_n) begin
            AST_RST_HIZ: assert (pin_oe == '0 && !irq_a_oe && !irq_b_oe); // R1
        end
    end

    AST_CLR_CAPT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == {1'b0, F_CAPT}) |=> (flag_a == '0)); // R9

    AST_CLR_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == {1'b1, F_PORT}) |=> (flag_b == '0)); // R9

    AST_CAPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_a) |=> $stable(capt_a)); // R8

    AST_MIRROR_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.mirror |-> (irq_a_o == irq_b_o && irq_a_oe == irq_b_oe)); // R10

    AST_OD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.open_drain |-> (!irq_a_o && !irq_b_o)); // R11

    AST_OD_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.open_drain && !cfg.mirror) |-> (irq_a_oe == (|flag_a))); // R11
endmodule

bind gpio_ioc gpio_ioc_chk #(.W(PORT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .pin_oe   (pin_oe),
    .irq_a_o  (irq_a_o),
    .irq_a_oe (irq_a_oe),
    .irq_b_o  (irq_b_o),
    .irq_b_oe (irq_b_oe),
    .flag_a   (port_flag[0]),
    .flag_b   (port_flag[1]),
    .capt_a   (port_capt[0]),
    .cfg      (cfg)
);

// File: tb/gpio_ioc_tb_top.sv
// Scoreboard bench: read tasks push expected values into a queue, and a
// monitor pops and compares them when bus_rdata becomes valid.
module gpio_ioc_tb_top;
    localparam int PW   = 8;
    localparam int FILT = 3;
    localparam logic [3:0] DIR = 0, POL = 1, IEN = 2, DEFV = 3, CMPS = 4,
                           PUEN = 5, PORT = 6, FLAG = 8, CAPT = 9, CFG = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [15:0]   pin_in = '0;
    logic [15:0]   pin_out, pin_oe, pin_pu;
    logic          irq_a_o, irq_a_oe, irq_b_o, irq_b_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;

    always #10 clk = ~clk;

    gpio_ioc #(.PORT_W(PW), .FILT_CYCLES(FILT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .irq_a_o(irq_a_o), .irq_a_oe(irq_a_oe),
        .irq_b_o(irq_b_o), .irq_b_oe(irq_b_oe)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: compare read data the cycle after each read strobe.
    always @(posedge clk) rd_d <= bus_rd;
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            check(tag_q.pop_front(), 16'(bus_rdata), 16'(exp_q.pop_front()));
        end
    end

    task automatic wr(bit p, logic [3:0] f, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {p, f}; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(bit p, logic [3:0] f, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = {p, f};
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (FILT + 6) @(negedge clk);
    endtask

    task automatic pulse(int bitn, int len);
        @(negedge clk);
        pin_in[bitn] = ~pin_in[bitn];
        repeat (len) @(negedge clk);
        pin_in[bitn] = ~pin_in[bitn];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset oe", {pin_oe[13:0], irq_a_oe, irq_b_oe}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle lines", {12'h0, irq_a_o, irq_a_oe, irq_b_o, irq_b_oe}, 16'hF);
        check("R1 all inputs", pin_oe, 16'h0);
        rd(0, DIR, 8'hFF, "R1 dir A");
        rd(1, DIR, 8'hFF, "R1 dir B");
        rd(0, CFG, 8'h00, "R1 cfg");

        // R2 output drive
        wr(0, DIR, 8'hF0);
        wr(0, PORT, 8'h5A);
        @(negedge clk);
        check("R2 oe", pin_oe, 16'h000F);
        check("R2 out", {8'h0, pin_out[7:0]}, 16'h005A);
        wr(0, DIR, 8'hFF);

        // R3 polarity
        pin_in[7:0] = 8'h3C;
        settle();
        rd(0, PORT, 8'h3C, "R3 plain");
        wr(0, POL, 8'h0F);
        rd(0, PORT, 8'h33, "R3 inverted");
        wr(0, POL, 8'h00);

        // R4 glitch filter, R5 change mode
        wr(0, IEN, 8'h01);
        pulse(0, FILT - 1);
        settle();
        rd(0, FLAG, 8'h00, "R4 short pulse no flag");
        rd(0, PORT, 8'h3C, "R4 short pulse no level");
        pulse(0, FILT + 1);
        settle();
        rd(0, FLAG, 8'h01, "R5 flag set");
        check("R10 irq a active", {14'h0, irq_a_o, irq_b_o}, 16'h1);
        rd(0, FLAG, 8'h01, "R9 flag read keeps");
        rd(0, CAPT, 8'h3D, "R8 capture first edge");
        check("R9 irq released", {15'h0, irq_a_o}, 16'h1);
        rd(0, FLAG, 8'h00, "R9 flag cleared");

        // R7 masking
        pulse(1, FILT + 2);
        settle();
        rd(0, FLAG, 8'h00, "R7 disabled pin");
        wr(0, DIR, 8'hFE);
        pulse(0, FILT + 2);
        settle();
        rd(0, FLAG, 8'h00, "R7 output pin");
        wr(0, DIR, 8'hFF);

        // R6 reference mode on port B
        wr(1, IEN, 8'h80);
        wr(1, CMPS, 8'h80);
        pin_in[15] = 1'b1;
        settle();
        check("R10 separate", {14'h0, irq_a_o, irq_b_o}, 16'h2);
        rd(1, CAPT, 8'h80, "R8 capture B");
        rd(1, FLAG, 8'h80, "R6 flag returns");

        // R10 mirror, R11 drive modes
        wr(0, CFG, 8'h01);
        @(negedge clk);
        check("R10 mirror", {14'h0, irq_a_o, irq_b_o}, 16'h0);
        wr(1, CFG, 8'h00);
        @(negedge clk);
        check("R10 unmirror", {14'h0, irq_a_o, irq_b_o}, 16'h2);
        wr(0, CFG, 8'h04);
        @(negedge clk);
        check("R11 active high", {12'h0, irq_a_o, irq_a_oe, irq_b_o, irq_b_oe}, 16'h7);
        wr(0, CFG, 8'h02);
        @(negedge clk);
        check("R11 open drain", {12'h0, irq_a_o, irq_a_oe, irq_b_o, irq_b_oe}, 16'h1);
        rd(0, CFG, 8'h02, "R11 cfg readback");
        pin_in[15] = 1'b0;
        settle();
        rd(1, PORT, 8'h00, "R9 port read B");
        check("R11 od released", {15'h0, irq_b_oe}, 16'h0);
        settle();
        rd(1, FLAG, 8'h00, "R6 no flag on match");

        // R12 pull-ups
        wr(1, PUEN, 8'hA5);
        wr(0, PUEN, 8'h0C);
        @(negedge clk);
        check("R12 pullups", pin_pu, 16'hA50C);

        // R1 second reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset hiz", {14'h0, irq_a_oe, irq_b_oe}, 16'h0);
        rst_n = 1'b1;
        rd(1, CFG, 8'h00, "R1 cfg after reset");
        rd(1, DIR, 8'hFF, "R1 dir after reset");
        check("R1 pullups cleared", pin_pu, 16'h0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule